// File: doc/BRIEF.md
# Pixel Serial Packet Transmitter

This block turns a parallel camera pixel stream into framed serial packets, one bit per shift clock. Each accepted sample is a 10-bit pixel (plus a second pixel when two sensors are combined), a line-valid flag and a frame-valid flag. The output packet always opens with a high start bit and closes with a low stop bit. The payload between them depends on the format: an 8-bit pixel with both flags, a full 10-bit pixel with no flags, or two 8-bit pixels from a master and a slave sensor.

Line and frame edges are also marked inside the pixel data, so a receiver that has only the data line can rebuild them. Short reserved codes are sent around each edge, and real pixels that would look like those codes are moved out of the way.

For column binning, each pixel packet is repeated back to back. An input-ready handshake holds the source while reserved codes or repeats are being sent. When no sample is offered, neutral idle packets keep the line busy. Two power-down inputs release the data and shift-clock outputs to high impedance.

Top module: `pix_serial_tx`

## Requirements
- R1: Packets follow one another with no gap, one bit per clock and lowest position first. Position 0 is always 1. The last position (11 for 12-bit packets, 17 for 18-bit packets) is always 0.
- R2: Format select 0 (and 3) gives 12-bit packets. Positions 1..8 carry pixel bits 2..9, position 9 carries the line flag and position 10 carries the frame flag.
- R3: Format select 1 gives 12-bit packets whose positions 1..10 carry pixel bits 0..9.
- R4: Format select 2 gives 18-bit packets. Positions 1..8 carry master bits 2..9 and positions 9..16 carry slave bits 2..9.
- R5: Reserved codes are sent as extra packets before an accepted sample's own packet. The order is: 2 when the line flag fell, 3 when the frame flag fell, 0 when the frame flag rose, 1 when the line flag rose. Flags are compared with the last sample sent. A reserved-code packet puts the code in every pixel field and carries the flags of the previous sample.
- R6: A sample with both flags high whose pixel (master or slave) is 0, 1, 2 or 3 is sent with the value 4 instead.
- R7: Binning select 0, 1 and 2/3 send each sample's packet 1, 2 and 4 times in a row. The packet length does not change.
- R8: A sample without both flags high is sent with pixel value 4 and its own flags. When no sample is offered, an idle packet with pixel value 4 and the flags of the last sample is sent.
- R9: in_ready is high only during the last bit of a packet, and only when no reserved code or repeat is still owed. A sample is taken on a clock edge where in_valid and in_ready are both high.
- R10: ser_data is high impedance while pwr_dn is set. The shift-clock power-down alone leaves it driven.
- R11: ser_clk follows clk only while both pwr_dn and clk_pwr_dn are clear; otherwise it is high impedance.
- R12: While reset is held, ser_data stays low. The first packet's start bit appears in the cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source offers a sample |
| in_ready | output | 1 | Transmitter takes the sample this edge |
| in_pix | input | 10 | Pixel (master pixel in stereo format) |
| in_slv | input | 10 | Slave pixel, used in stereo format |
| in_lv | input | 1 | Line-valid flag of the sample |
| in_fv | input | 1 | Frame-valid flag of the sample |
| fmt_sel | input | 2 | 0/3: 8-bit, 1: 10-bit, 2: stereo |
| bin_sel | input | 2 | 0: 1x, 1: 2x, 2/3: 4x repetition |
| pwr_dn | input | 1 | Main power-down |
| clk_pwr_dn | input | 1 | Shift-clock power-down |
| ser_data | output | 1 | Serial data, tri-state |
| ser_clk | output | 1 | Forwarded shift clock, tri-state |

## Verification
One short frame is replayed in each format. It contains blanking, a frame start, two lines, a line end on its own, and a combined line-and-frame end followed at once by a combined start. This separates the code ordering for single edges from the ordering for paired edges, and checks that the flags are carried from the previous sample. Pixel values 0, 2, 3 and 1023 sit inside lines to tell remapped values from pass-through values. Slave values differ from master values so that swapped stereo fields are caught. The same frame is replayed with 2x and 4x repetition. Idle streams and the power-down combinations are checked on their own, with the lines pulled up so that high impedance can be told apart from a driven level.

// File: rtl/pst_pkg.sv
package pst_pkg;
  localparam int PIX_W     = 10;
  localparam int PKT_MAX   = 18;
  localparam int SHORT_LEN = 12;
  localparam int LONG_LEN  = 18;
  localparam int LEN_W     = $clog2(PKT_MAX + 1);
  localparam int REP_W     = 2;
  localparam int N_SYNC    = 4;
  localparam int HI_W      = 8;
  localparam int LO_DROP   = PIX_W - HI_W;
  localparam logic [PIX_W-1:0] SAFE_WORD = PIX_W'(4);

  typedef enum logic [1:0] {
    FMT_B8  = 2'd0,
    FMT_B10 = 2'd1,
    FMT_DUO = 2'd2,
    FMT_ALT = 2'd3
  } fmt_e;

  // Values at or below the highest reserved code are lifted to the safe word.
  function automatic logic [PIX_W-1:0] lift_reserved(input logic [PIX_W-1:0] p);
    return (p < SAFE_WORD) ? SAFE_WORD : p;
  endfunction

  function automatic logic [LEN_W-1:0] len_of(input fmt_e f);
    return (f == FMT_DUO) ? LEN_W'(LONG_LEN) : LEN_W'(SHORT_LEN);
  endfunction

  // Extra sends after the first one for a binning setting.
  function automatic logic [REP_W-1:0] extra_sends(input logic [1:0] b);
    case (b)
      2'd0:    return REP_W'(0);
      2'd1:    return REP_W'(1);
      default: return REP_W'(3);
    endcase
  endfunction

  // Pending slot index -> reserved code; slot order is the send priority.
  function automatic logic [PIX_W-1:0] code_of(input int slot);
    case (slot)
      0:       return PIX_W'(2);
      1:       return PIX_W'(3);
      2:       return PIX_W'(0);
      default: return PIX_W'(1);
    endcase
  endfunction

  function automatic logic [PKT_MAX-1:0] frame_pkt(input fmt_e f,
                                                   input logic [PIX_W-1:0] m,
                                                   input logic [PIX_W-1:0] s,
                                                   input logic lv, input logic fv);
    logic [PKT_MAX-1:0] r;
    r    = '0;
    r[0] = 1'b1;
    case (f)
      FMT_B10: r[PIX_W:1] = m;
      FMT_DUO: begin
        r[HI_W:1]        = m[PIX_W-1:LO_DROP];
        r[2*HI_W:HI_W+1] = s[PIX_W-1:LO_DROP];
      end
      default: begin
        r[HI_W:1]   = m[PIX_W-1:LO_DROP];
        r[HI_W+1]   = lv;
        r[HI_W+2]   = fv;
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/pst_shifter.sv
module pst_shifter
  import pst_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PKT_MAX-1:0] ld_pkt,
  input  logic [LEN_W-1:0]   ld_len,
  output logic               last_bit,
  output logic               ser_bit
);
  logic [PKT_MAX-1:0] sh;
  logic [LEN_W-1:0]   cnt;
  logic [LEN_W-1:0]   len_q;
  logic               run;

  assign last_bit = !run || (cnt == len_q - LEN_W'(1));
  assign ser_bit  = sh[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh    <= '0;
      cnt   <= '0;
      len_q <= LEN_W'(SHORT_LEN);
      run   <= 1'b0;
    end else if (last_bit) begin
      sh    <= ld_pkt;
      len_q <= ld_len;
      cnt   <= '0;
      run   <= 1'b1;
    end else begin
      sh  <= sh >> 1;
      cnt <= cnt + LEN_W'(1);
    end
  end

  assert_start_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == '0) |-> ser_bit);

  assert_stop_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == len_q - LEN_W'(1)) |-> !ser_bit);
endmodule

// File: rtl/pst_seq.sv
module pst_seq
  import pst_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               last_bit,
  input  logic               in_valid,
  input  logic [PIX_W-1:0]   in_pix,
  input  logic [PIX_W-1:0]   in_slv,
  input  logic               in_lv,
  input  logic               in_fv,
  input  fmt_e               fmt,
  input  logic [1:0]         bin_sel,
  output logic               in_ready,
  output logic [PKT_MAX-1:0] ld_pkt,
  output logic [LEN_W-1:0]   ld_len
);
  logic [PIX_W-1:0]  hold_pix, hold_slv;
  logic              hold_lv, hold_fv;
  logic              st_lv, st_fv;
  logic [N_SYNC-1:0] pend, pend_nx, edge_set, pick;
  logic              owed, owed_nx;
  logic [REP_W-1:0]  rep;

  logic              accept;
  logic [PIX_W-1:0]  src_pix, src_slv, code, pay_m, pay_s;
  logic              src_lv, src_fv, in_line;
  logic              ev_sync, ev_data_first, ev_data_rep, ev_idle;

  assign in_ready = last_bit && (pend == '0) && !owed && (rep == '0);
  assign accept   = in_ready && in_valid;

  assign src_pix = accept ? in_pix : hold_pix;
  assign src_slv = accept ? in_slv : hold_slv;
  assign src_lv  = accept ? in_lv  : hold_lv;
  assign src_fv  = accept ? in_fv  : hold_fv;

  // Slot order = send order: line end, frame end, frame start, line start.
  assign edge_set = {!st_lv && in_lv, !st_fv && in_fv, st_fv && !in_fv, st_lv && !in_lv};
  assign pend_nx  = accept ? edge_set : pend;
  assign owed_nx  = accept || owed;
  assign pick     = pend_nx & (~pend_nx + N_SYNC'(1));

  always_comb begin
    code = '0;
    for (int i = 0; i < N_SYNC; i++) begin
      if (pick[i]) code = code | code_of(i);
    end
  end

  assign ev_sync       = last_bit && (pend_nx != '0);
  assign ev_data_first = last_bit && (pend_nx == '0) && owed_nx;
  assign ev_data_rep   = last_bit && (pend_nx == '0) && !owed_nx && (rep != '0);
  assign ev_idle       = last_bit && (pend_nx == '0) && !owed_nx && (rep == '0);

  assign in_line = src_lv && src_fv;
  assign pay_m   = in_line ? lift_reserved(src_pix) : SAFE_WORD;
  assign pay_s   = in_line ? lift_reserved(src_slv) : SAFE_WORD;

  always_comb begin
    if (ev_sync)
      ld_pkt = frame_pkt(fmt, code, code, st_lv, st_fv);
    else if (ev_data_first || ev_data_rep)
      ld_pkt = frame_pkt(fmt, pay_m, pay_s, src_lv, src_fv);
    else
      ld_pkt = frame_pkt(fmt, SAFE_WORD, SAFE_WORD, st_lv, st_fv);
  end
  assign ld_len = len_of(fmt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_pix <= '0;
      hold_slv <= '0;
      hold_lv  <= 1'b0;
      hold_fv  <= 1'b0;
      st_lv    <= 1'b0;
      st_fv    <= 1'b0;
      pend     <= '0;
      owed     <= 1'b0;
      rep      <= '0;
    end else begin
      if (accept) begin
        hold_pix <= in_pix;
        hold_slv <= in_slv;
        hold_lv  <= in_lv;
        hold_fv  <= in_fv;
      end
      if (last_bit) begin
        pend <= pend_nx & ~pick;
        owed <= ev_sync ? owed_nx : 1'b0;
        if (ev_data_first) begin
          rep   <= extra_sends(bin_sel);
          st_lv <= src_lv;
          st_fv <= src_fv;
        end else if (ev_data_rep) begin
          rep <= rep - REP_W'(1);
        end
      end
    end
  end

  assert_ready_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);

  assert_code_before_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_sync |=> owed);

  assert_no_reserved_pixel_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_data_first && in_line && fmt == FMT_B10) |-> (ld_pkt[PIX_W:1] >= SAFE_WORD));

  assert_idle_not_taking_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_idle |=> !owed);
endmodule

// File: rtl/pst_pads.sv
module pst_pads (
  input  logic clk,
  input  logic ser_bit,
  input  logic pwr_dn,
  input  logic clk_pwr_dn,
  output wire  ser_data,
  output wire  ser_clk
);
  logic data_oe, clk_oe;

  assign data_oe  = !pwr_dn;
  assign clk_oe   = !(pwr_dn || clk_pwr_dn);
  assign ser_data = data_oe ? ser_bit : 1'bz;
  assign ser_clk  = clk_oe ? clk : 1'bz;
endmodule

// File: rtl/pix_serial_tx.sv
module pix_serial_tx
  import pst_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_pix,
  input  logic [PIX_W-1:0] in_slv,
  input  logic             in_lv,
  input  logic             in_fv,
  input  logic [1:0]       fmt_sel,
  input  logic [1:0]       bin_sel,
  input  logic             pwr_dn,
  input  logic             clk_pwr_dn,
  output wire              ser_data,
  output wire              ser_clk
);
  logic [PKT_MAX-1:0] ld_pkt;
  logic [LEN_W-1:0]   ld_len;
  logic               last_bit;
  logic               ser_bit;

  pst_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .last_bit (last_bit),
    .in_valid (in_valid),
    .in_pix   (in_pix),
    .in_slv   (in_slv),
    .in_lv    (in_lv),
    .in_fv    (in_fv),
    .fmt      (fmt_e'(fmt_sel)),
    .bin_sel  (bin_sel),
    .in_ready (in_ready),
    .ld_pkt   (ld_pkt),
    .ld_len   (ld_len)
  );

  pst_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_pkt   (ld_pkt),
    .ld_len   (ld_len),
    .last_bit (last_bit),
    .ser_bit  (ser_bit)
  );

  pst_pads u_pads (
    .clk        (clk),
    .ser_bit    (ser_bit),
    .pwr_dn     (pwr_dn),
    .clk_pwr_dn (clk_pwr_dn),
    .ser_data   (ser_data),
    .ser_clk    (ser_clk)
  );
endmodule

// File: tb/pix_serial_tx_bench.sv
module pix_serial_tx_bench;
  localparam int CLK_NS = 20;
  localparam int MAXS   = 16;
  localparam int MAXP   = 256;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [9:0] in_pix = '0, in_slv = '0;
  logic       in_lv = 1'b0, in_fv = 1'b0;
  logic [1:0] fmt_sel = 2'd0, bin_sel = 2'd0;
  logic       pwr_dn = 1'b0, clk_pwr_dn = 1'b0;
  wire        ser_data_w, ser_clk_w;

  pullup (ser_data_w);
  pullup (ser_clk_w);

  always #(CLK_NS/2) clk = ~clk;

  pix_serial_tx u_pix_serial_tx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .in_slv(in_slv), .in_lv(in_lv), .in_fv(in_fv),
    .fmt_sel(fmt_sel), .bin_sel(bin_sel), .pwr_dn(pwr_dn), .clk_pwr_dn(clk_pwr_dn),
    .ser_data(ser_data_w), .ser_clk(ser_clk_w)
  );

  int n_chk = 0, n_bad = 0;
  logic [9:0]  s_pix [MAXS];
  logic [9:0]  s_slv [MAXS];
  logic        s_lv  [MAXS];
  logic        s_fv  [MAXS];
  int          n_smp;
  logic [17:0] exp_q [MAXP];
  logic [17:0] got_q [MAXP];
  int          n_exp;
  int          rdy_bad;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  function automatic int plen(int f);
    return (f == 2) ? 18 : 12;
  endfunction

  function automatic logic [17:0] mk(int f, logic [9:0] m, logic [9:0] s, logic lv, logic fv);
    logic [17:0] r = '0;
    r[0] = 1'b1;
    if (f == 2) begin
      for (int k = 0; k < 8; k++) begin r[1+k] = m[2+k]; r[9+k] = s[2+k]; end
    end else if (f == 1) begin
      for (int k = 0; k < 10; k++) r[1+k] = m[k];
    end else begin
      for (int k = 0; k < 8; k++) r[1+k] = m[2+k];
      r[9] = lv; r[10] = fv;
    end
    return r;
  endfunction

  function automatic logic [9:0] safe(logic [9:0] p);
    return (p <= 10'd3) ? 10'd4 : p;
  endfunction

  task automatic push(logic [17:0] p);
    exp_q[n_exp] = p;
    n_exp++;
  endtask

  // Expected packet list for the loaded sample set (R5 order, R6, R7, R8).
  task automatic build_expected(int f, int b);
    logic pl = 1'b0, pf = 1'b0;
    int reps = (b == 0) ? 1 : (b == 1) ? 2 : 4;
    n_exp = 0;
    for (int i = 0; i < n_smp; i++) begin
      logic [9:0] m, s;
      if (pl && !s_lv[i]) push(mk(f, 10'd2, 10'd2, pl, pf));
      if (pf && !s_fv[i]) push(mk(f, 10'd3, 10'd3, pl, pf));
      if (!pf && s_fv[i]) push(mk(f, 10'd0, 10'd0, pl, pf));
      if (!pl && s_lv[i]) push(mk(f, 10'd1, 10'd1, pl, pf));
      m = (s_lv[i] && s_fv[i]) ? safe(s_pix[i]) : 10'd4;
      s = (s_lv[i] && s_fv[i]) ? safe(s_slv[i]) : 10'd4;
      for (int r = 0; r < reps; r++) push(mk(f, m, s, s_lv[i], s_fv[i]));
      pl = s_lv[i];
      pf = s_fv[i];
    end
  endtask

  task automatic load_frame();
    logic [9:0] pv [11] = '{10'd100, 10'd200, 10'd0, 10'd3, 10'd1023, 10'd517,
                            10'd9, 10'd2, 10'd7, 10'd64, 10'd5};
    logic       fv [11] = '{0, 1, 1, 1, 1, 1, 1, 1, 0, 1, 0};
    logic       lv [11] = '{0, 0, 1, 1, 1, 1, 0, 1, 0, 1, 0};
    n_smp = 11;
    for (int i = 0; i < n_smp; i++) begin
      s_pix[i] = pv[i];
      s_slv[i] = (i == 3) ? 10'd1 : (pv[i] ^ 10'h2a8);
      s_lv[i]  = lv[i];
      s_fv[i]  = fv[i];
    end
  endtask

  task automatic drive(int i);
    in_pix = s_pix[i]; in_slv = s_slv[i]; in_lv = s_lv[i]; in_fv = s_fv[i];
  endtask

  task automatic hold_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic feed_all();
    int i = 0;
    while (i < n_smp) begin
      logic acc = in_ready;
      @(posedge clk);
      if (acc) i++;
      @(negedge clk);
      if (i < n_smp) drive(i);
    end
    in_valid = 1'b0;
  endtask

  // Packet capture: start bit 1 at position 0, lowest position first (R1, R9).
  task automatic collect(int f, int cnt);
    int len = plen(f);
    for (int p = 0; p < cnt; p++) begin
      logic [17:0] pk = '0;
      do @(negedge clk); while (ser_data_w !== 1'b1);
      pk[0] = 1'b1;
      if (in_ready) rdy_bad++;
      for (int k = 1; k < len; k++) begin
        @(negedge clk);
        pk[k] = ser_data_w;
        if (in_ready && k != len - 1) rdy_bad++;
      end
      got_q[p] = pk;
    end
  endtask

  task automatic run_stream(int f, int b, string req);
    load_frame();
    build_expected(f, b);
    fmt_sel = 2'(f); bin_sel = 2'(b);
    hold_reset();
    in_valid = 1'b1;
    drive(0);
    rst_n = 1'b1;
    rdy_bad = 0;
    fork
      feed_all();
      collect(f, n_exp);
    join
    for (int p = 0; p < n_exp; p++)
      chk(req, $sformatf("fmt %0d bin %0d packet %0d", f, b, p), 32'(got_q[p]), 32'(exp_q[p]));
    chk("R9", "ready raised away from a last bit", 32'(rdy_bad), 32'd0);
  endtask

  task automatic t_reset();
    fmt_sel = 2'd0; bin_sel = 2'd0; in_valid = 1'b0;
    rst_n = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk("R12", "line during reset", 32'(ser_data_w), 32'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "start bit right after reset", 32'(ser_data_w), 32'd1);
  endtask

  task automatic t_idle(int f);
    fmt_sel = 2'(f); bin_sel = 2'd0;
    hold_reset();
    in_valid = 1'b0;
    rst_n = 1'b1;
    rdy_bad = 0;
    collect(f, 3);
    for (int p = 0; p < 3; p++)
      chk("R8", $sformatf("idle packet %0d fmt %0d", p, f), 32'(got_q[p]), 32'(mk(f, 10'd4, 10'd4, 1'b0, 1'b0)));
  endtask

  task automatic t_power();
    int d1, c1, d0;
    fmt_sel = 2'd0; bin_sel = 2'd0;
    hold_reset();
    in_valid = 1'b0;
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    pwr_dn = 1'b1; clk_pwr_dn = 1'b0;
    d1 = 0; c1 = 0;
    repeat (24) begin
      @(negedge clk);
      if (ser_data_w === 1'b1) d1++;
      if (ser_clk_w === 1'b1) c1++;
    end
    chk("R10", "data released under main power-down", 32'(d1), 32'd24);
    chk("R11", "clock released under main power-down", 32'(c1), 32'd24);
    pwr_dn = 1'b0; clk_pwr_dn = 1'b1;
    d0 = 0; c1 = 0;
    repeat (24) begin
      @(negedge clk);
      if (ser_data_w === 1'b0) d0++;
      if (ser_clk_w === 1'b1) c1++;
    end
    chk("R10", "data still driven under clock power-down", 32'(d0 > 0), 32'd1);
    chk("R11", "clock released under clock power-down", 32'(c1), 32'd24);
    clk_pwr_dn = 1'b0;
    @(negedge clk);
    chk("R11", "clock driven low at falling edge", 32'(ser_clk_w), 32'd0);
    @(posedge clk); #1;
    chk("R11", "clock driven high after rising edge", 32'(ser_clk_w), 32'd1);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    t_reset();
    run_stream(0, 0, "R1 R2 R5 R6 R8");
    run_stream(1, 0, "R1 R3 R5 R6 R8");
    run_stream(2, 0, "R1 R4 R5 R6");
    run_stream(0, 1, "R7 2x");
    run_stream(1, 2, "R7 4x");
    t_idle(0);
    t_idle(1);
    t_power();
    summary();
    $finish;
  end
endmodule